// File: doc/BRIEF.md
# Multiplexed Bidirectional GPIO Port

An eight-pin general-purpose I/O port for a small controller. Each pin has a direction bit and an output latch bit. Register-bus strobes write the latch, write the direction register, write a two-bit mode register, and set or clear single latch bits. Read strobes return either the pin levels or the direction register. The pin-side interface gives each pin an output enable and an output value, and takes one input level per pin.

Several pins are shared with other functions, and these change how the port behaves.

- The four low pins can be handed to analog comparator inputs. They then read as zero.
- Pins 3 and 4 can carry two comparator results instead of their latch bits.
- Pins 7 and 6 can be taken over by the oscillator configuration.
- Pin 5 is input-only.
- Pin 4 can only pull low.

Pin inputs pass through a two-flop synchronizer before anything uses them. Single-bit set and clear operations rebuild the whole latch from those synchronized, filtered pin values. A pin held at the opposite level from its latch bit, or a pin in analog mode, therefore overwrites that latch bit during the operation.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the block has these values.
  - The direction register is all ones and the latch is zero.
  - The mode register is analog on, comparator output off.
  - Every `pin_oe` bit is 0, `pin_out` is 0 and `rd_data` is 0.
- R2: On an ordinary pin (bits 0-3, 6, 7, with no mode override), a direction bit of 0 gives `pin_oe`=1 and `pin_out`=latch bit. A direction bit of 1 gives `pin_oe`=0.
- R3: A `rd_port_en` pulse loads `rd_data` at the same edge with the port view. The port view is the synchronized pin levels after masking. `rd_data` is 0 in any cycle after an edge with no read strobe. A pin level must be stable for two edges before the edge of the read strobe.
- R4: A `rd_dir_en` pulse returns the direction register. `rd_port_en` wins if both are high. Bit 5 of the direction register always reads 1, whatever value is written.
- R5: `wr_data_en` loads all of `wr_val` into the latch. `bit_set_en` and `bit_clr_en` load the port view with bit `bit_sel` forced to 1 or to 0. The byte write wins over set, and set wins over clear.
- R6: Mode bit `wr_val[0]` (analog) makes port-view bits 3:0 read 0, whatever the pin levels.
- R7: Pin 5 is never driven: `pin_oe[5]` is always 0.
- R8: Pin 4 is open-drain. `pin_out[4]` is always 0, and `pin_oe[4]` is 1 only when its direction bit is 0 and its source bit is 0.
- R9: While `osc_takeover` is 1, `pin_oe[7:6]` is 0 and port-view bits 7:6 read 0. The stored direction bits 7:6 can still be read back.
- R10: Mode bit `wr_val[1]` (comparator output) changes the source of two pins.
  - Pin 3 takes its source from `cmp_res[0]` instead of latch bit 3.
  - Pin 4 takes its source from `cmp_res[1]` instead of latch bit 4.
  - Both pins still obey their direction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data_en | input | 1 | Write the whole latch from wr_val |
| wr_dir_en | input | 1 | Write the direction register from wr_val |
| wr_mode_en | input | 1 | Write the mode register from wr_val[1:0] |
| bit_set_en | input | 1 | Read-modify-write: set bit bit_sel |
| bit_clr_en | input | 1 | Read-modify-write: clear bit bit_sel |
| bit_sel | input | 3 | Bit index for set or clear |
| wr_val | input | 8 | Write data |
| rd_port_en | input | 1 | Read the port view |
| rd_dir_en | input | 1 | Read the direction register |
| rd_data | output | 8 | Registered read data |
| osc_takeover | input | 1 | Oscillator owns pins 7:6 |
| cmp_res | input | 2 | Comparator results for pins 3 and 4 |
| pin_in | input | 8 | Pin input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
The hardest case to reach is the latch corruption caused by a bit set or clear. It appears only when the synchronized pin level differs from the latch. That happens in two ways: an outside agent holds a driven pin at the opposite level, or the analog mode masks the low pins.

The bench resolves each pin as a net. An external driver has the highest priority, then the port's driver, then a pull-up. The bench holds one pin low against a latch of ones and waits for the synchronizer, then issues a set on a different bit. It releases the pin and checks that the latch bit of the held pin has been cleared, as seen on `pin_out`. It repeats this with the analog mode on.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and types for the multiplexed GPIO port.
// Assumes an eight-pin port; special pin positions are fixed by behaviour.
package gpio_port_pkg;
    localparam int PORT_W      = 8;
    localparam int ANA_CNT     = 4;  // pins 0..ANA_CNT-1 may be analog inputs
    localparam int CMP_A_BIT   = 3;  // carries cmp_res[0] in comparator-output mode
    localparam int OD_BIT      = 4;  // open-drain pin, carries cmp_res[1]
    localparam int IN_ONLY_BIT = 5;  // input-only pin
    localparam int OSC_LO_BIT  = 6;  // pins OSC_LO_BIT.. may be owned by oscillator

    typedef struct packed {
        logic cmp_out;   // wr_val[1]
        logic analog;    // wr_val[0]
    } port_mode_t;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for pin inputs.
// Assumes inputs are asynchronous levels; output lags by STAGES clocks.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin levels one stage along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else if (s == 0) stg[s] <= d;
                else stg[s] <= stg[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Module: latch, direction and mode registers with read-modify-write bit ops.
// Assumes pin_view is the synchronized, masked port value; priority is
// byte write, then bit set, then bit clear.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int SEL_W = $clog2(PORT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic              wr_dir_en,
    input  logic              wr_mode_en,
    input  logic              bit_set_en,
    input  logic              bit_clr_en,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [PORT_W-1:0] wr_val,
    input  logic [PORT_W-1:0] pin_view,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q,
    output port_mode_t        mode_q
);
    localparam logic [PORT_W-1:0] IN_ONLY_MASK = PORT_W'(1) << IN_ONLY_BIT;

    logic [PORT_W-1:0] sel_mask;
    assign sel_mask = PORT_W'(1) << bit_sel;

    // Update the output latch: byte write or read-modify-write bit op.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= '0;
        else if (wr_data_en) latch_q <= wr_val;
        else if (bit_set_en) latch_q <= pin_view | sel_mask;
        else if (bit_clr_en) latch_q <= pin_view & ~sel_mask;
    end

    // Update the direction register; the input-only bit stays 1.
    always_ff @(posedge clk) begin
        if (!rst_n)         dir_q <= '1;
        else if (wr_dir_en) dir_q <= wr_val | IN_ONLY_MASK;
    end

    // Update the mode register; reset leaves the low pins analog.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.analog  <= 1'b1;
            mode_q.cmp_out <= 1'b0;
        end else if (wr_mode_en) begin
            mode_q.analog  <= wr_val[0];
            mode_q.cmp_out <= wr_val[1];
        end
    end

    assert_byte_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_en |=> latch_q == $past(wr_val));
    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_set_en && !wr_data_en) |=> latch_q[$past(bit_sel)]);
    assert_dir_in_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir_en |=> dir_q[IN_ONLY_BIT]);
endmodule

// File: rtl/gpio_pin_mux.sv
// Module: per-pin drive and read selection with alternate-function overrides.
// Assumes pin_sync is already synchronized; purely combinational datapath.
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] dir_q,
    input  port_mode_t        mode_q,
    input  logic              osc_takeover,
    input  logic [1:0]        cmp_res,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_view
);
    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_pin
            // Choose the driver for this pin from its role.
            if (i == IN_ONLY_BIT) begin : g_in_only
                assign pin_oe[i]  = ~dir_q[i] & 1'b0;
                assign pin_out[i] = 1'b0;
            end else if (i == OD_BIT) begin : g_open_drain
                logic src;
                assign src        = mode_q.cmp_out ? cmp_res[1] : latch_q[i];
                assign pin_oe[i]  = ~dir_q[i] & ~src;
                assign pin_out[i] = 1'b0;
            end else if (i == CMP_A_BIT) begin : g_cmp_a
                assign pin_oe[i]  = ~dir_q[i];
                assign pin_out[i] = mode_q.cmp_out ? cmp_res[0] : latch_q[i];
            end else if (i >= OSC_LO_BIT) begin : g_osc
                assign pin_oe[i]  = ~dir_q[i] & ~osc_takeover;
                assign pin_out[i] = latch_q[i];
            end else begin : g_plain
                assign pin_oe[i]  = ~dir_q[i];
                assign pin_out[i] = latch_q[i];
            end

            // Mask the read view where an alternate function owns the pin.
            if (i < ANA_CNT) begin : g_view_ana
                assign pin_view[i] = pin_sync[i] & ~mode_q.analog;
            end else if (i >= OSC_LO_BIT) begin : g_view_osc
                assign pin_view[i] = pin_sync[i] & ~osc_takeover;
            end else begin : g_view_plain
                assign pin_view[i] = pin_sync[i];
            end
        end
    endgenerate

    assert_in_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe[IN_ONLY_BIT]);
    assert_open_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_out[OD_BIT]);
    assert_osc_owns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        osc_takeover |-> (pin_oe[PORT_W-1:OSC_LO_BIT] == '0
                          && pin_view[PORT_W-1:OSC_LO_BIT] == '0));
    assert_analog_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.analog |-> pin_view[ANA_CNT-1:0] == '0);
endmodule

// File: rtl/gpio_mux_port.sv
// Module: top of the multiplexed bidirectional GPIO port.
// Assumes synchronous active-low reset and single-cycle strobes; read data
// is registered and returns to zero when no read strobe is present.
module gpio_mux_port
    import gpio_port_pkg::*;
#(
    parameter int PORT_W      = gpio_port_pkg::PORT_W,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(PORT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic              wr_dir_en,
    input  logic              wr_mode_en,
    input  logic              bit_set_en,
    input  logic              bit_clr_en,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [PORT_W-1:0] wr_val,
    input  logic              rd_port_en,
    input  logic              rd_dir_en,
    output logic [PORT_W-1:0] rd_data,
    input  logic              osc_takeover,
    input  logic [1:0]        cmp_res,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out
);
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] pin_view;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;
    port_mode_t        mode_q;

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_regs #(.PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_data_en(wr_data_en), .wr_dir_en(wr_dir_en), .wr_mode_en(wr_mode_en),
        .bit_set_en(bit_set_en), .bit_clr_en(bit_clr_en), .bit_sel(bit_sel),
        .wr_val(wr_val), .pin_view(pin_view),
        .latch_q(latch_q), .dir_q(dir_q), .mode_q(mode_q)
    );

    gpio_pin_mux #(.PORT_W(PORT_W)) u_mux (
        .clk(clk), .rst_n(rst_n),
        .latch_q(latch_q), .dir_q(dir_q), .mode_q(mode_q),
        .osc_takeover(osc_takeover), .cmp_res(cmp_res),
        .pin_sync(pin_sync),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_view(pin_view)
    );

    // Register the read data; port read wins over direction read.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_data <= '0;
        else if (rd_port_en) rd_data <= pin_view;
        else if (rd_dir_en)  rd_data <= dir_q;
        else                 rd_data <= '0;
    end

    assert_port_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_port_en |=> rd_data == $past(pin_view));
    assert_idle_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_port_en && !rd_dir_en) |=> rd_data == '0);
    assert_dir_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dir_en && !rd_port_en) |=> rd_data[IN_ONLY_BIT]);
endmodule

// File: tb/gpio_mux_port_tb.sv
// Bench: pins resolved as nets (external driver, then port driver, then
// pull-up); expected values computed from the requirements.
module gpio_mux_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_data_en = 0, wr_dir_en = 0, wr_mode_en = 0;
    logic       bit_set_en = 0, bit_clr_en = 0;
    logic [2:0] bit_sel = '0;
    logic [7:0] wr_val = '0;
    logic       rd_port_en = 0, rd_dir_en = 0;
    logic [7:0] rd_data;
    logic       osc_takeover = 0;
    logic [1:0] cmp_res = '0;
    logic [7:0] pad, pin_oe, pin_out;
    logic [7:0] ext_en = '0, ext_val = '0;
    int         n_run = 0, n_fail = 0;
    logic [7:0] got;

    always #5 clk = ~clk;

    // Pin resolution: external holder, then port driver, then pull-up.
    always_comb begin
        for (int i = 0; i < 8; i++)
            pad[i] = ext_en[i] ? ext_val[i] : (pin_oe[i] ? pin_out[i] : 1'b1);
    end

    gpio_mux_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_data_en(wr_data_en), .wr_dir_en(wr_dir_en), .wr_mode_en(wr_mode_en),
        .bit_set_en(bit_set_en), .bit_clr_en(bit_clr_en), .bit_sel(bit_sel),
        .wr_val(wr_val), .rd_port_en(rd_port_en), .rd_dir_en(rd_dir_en),
        .rd_data(rd_data), .osc_takeover(osc_takeover), .cmp_res(cmp_res),
        .pin_in(pad), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // kind: 0 data, 1 dir, 2 mode
    task automatic wr(input int kind, input logic [7:0] v);
        @(negedge clk);
        wr_val = v;
        wr_data_en = (kind == 0); wr_dir_en = (kind == 1); wr_mode_en = (kind == 2);
        @(negedge clk);
        wr_data_en = 0; wr_dir_en = 0; wr_mode_en = 0;
    endtask

    task automatic bitop(input bit set, input logic [2:0] b);
        @(negedge clk);
        bit_sel = b; bit_set_en = set; bit_clr_en = !set;
        @(negedge clk);
        bit_set_en = 0; bit_clr_en = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input bit port, output logic [7:0] v);
        @(negedge clk);
        rd_port_en = port; rd_dir_en = !port;
        @(negedge clk);
        rd_port_en = 0; rd_dir_en = 0;
        v = rd_data;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
        rd(0, got); chk("R1 dir", got, 8'hFF);
        settle();
        rd(1, got); chk("R1 R6 analog read", got, 8'hF0);
        @(negedge clk); chk("R3 idle read zero", rd_data, 8'h00);

        // Digital mode, all outputs; R2 R4 direction sweep with latch 0
        wr(2, 8'h00);
        wr(0, 8'h00);
        for (int d = 0; d < 256; d++) begin
            wr(1, 8'(d));
            chk("R2 R7 R8 oe", pin_oe, ~(8'(d) | 8'h20));
            rd(0, got); chk("R4 dir read", got, 8'(d) | 8'h20);
        end

        // R2 R3 R8 latch sweep with all directions out
        wr(1, 8'h00);
        for (int v = 0; v < 256; v++) begin
            wr(0, 8'(v));
            chk("R2 out", pin_out & 8'hCF, 8'(v) & 8'hCF);
            chk("R8 od oe", pin_oe, 8'hDF & ~(8'(v) & 8'h10));
            chk("R8 od out", {7'd0, pin_out[4]}, 8'h00);
            settle();
            rd(1, got); chk("R3 port read", got, 8'(v) | 8'h20);
        end

        // R5 bit clear from pin view
        wr(0, 8'hFF); settle();
        bitop(0, 3'd2);
        chk("R5 clear", pin_out & 8'hCF, 8'hCB);

        // R5 priority: byte write beats bit set
        @(negedge clk);
        wr_val = 8'h55; wr_data_en = 1; bit_set_en = 1; bit_sel = 3'd1;
        @(negedge clk);
        wr_data_en = 0; bit_set_en = 0;
        chk("R5 priority", pin_out & 8'hCF, 8'h45);

        // R5 corruption: pin 1 held low externally during set of bit 0
        wr(0, 8'hFF);
        ext_en = 8'h02; ext_val = 8'h00;
        settle();
        bitop(1, 3'd0);
        ext_en = 8'h00;
        chk("R5 rmw corruption", pin_out & 8'hCF, 8'hCD);

        // R6 analog mode: set bit 6 wipes low latch bits
        wr(2, 8'h01);
        wr(0, 8'hFF); settle();
        bitop(1, 3'd6);
        chk("R6 analog rmw", pin_out & 8'hCF, 8'hC0);
        settle();
        rd(1, got); chk("R6 analog read", got, 8'hF0);
        wr(2, 8'h00);

        // R9 oscillator takeover
        wr(0, 8'hFF);
        osc_takeover = 1'b1;
        settle();
        chk("R9 oe", pin_oe & 8'hC0, 8'h00);
        rd(1, got); chk("R9 read", got, 8'h3F);
        rd(0, got); chk("R9 dir kept", got, 8'h20);
        osc_takeover = 1'b0;
        @(negedge clk);
        chk("R9 released oe", pin_oe & 8'hC0, 8'hC0);

        // R10 comparator outputs
        wr(0, 8'h00);
        wr(2, 8'h02);
        for (int r = 0; r < 4; r++) begin
            @(negedge clk); cmp_res = 2'(r);
            @(negedge clk);
            chk("R10 pin3 out", {7'd0, pin_out[3]}, {7'd0, cmp_res[0]});
            chk("R10 pin4 oe", {7'd0, pin_oe[4]}, {7'd0, ~cmp_res[1]});
        end
        wr(1, 8'h08);
        chk("R10 dir gates", {7'd0, pin_oe[3]}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule